// File: doc/BRIEF.md
# Program Completion Status Readback

This block sits on the read path of a word-wide non-volatile array and decides what a host sees while the internal program timer runs. When the timer is idle, every read returns the stored word. While the timer is busy, the block replaces some bits with progress status, so a host can detect the end of the cycle by reading alone. Two methods are offered at once, in every byte lane. The top bit of a lane reads inverted against the word that was loaded last, but only when the host reads that word's address. The bit just below it flips on every new read access, whatever the address.

The control inputs are active-low pin levels, sampled on each clock edge. A read access is in progress while chip select and output enable are low and write enable is high. Each access returns one response, and the response is registered, so it appears one clock after the pins are sampled. There is no handshake and no back-pressure, because the host samples the bus while it holds the access. An access begins on the first sampled cycle of that condition, so either select line can act as the strobe. The bus-drive output stands in for the high-impedance state. When it is low, the data output reads zero.

Top module: `status_readback`

## Requirements
- R1: bus_drive is 1 one clock after an edge where chip_sel_n=0, out_en_n=0 and wr_en_n=1 are sampled, and 0 after any other sample; while bus_drive is 0, bus_q is 0.
- R2: With prog_busy low, a driven bus_q equals array_q as sampled at the previous edge, on all 16 bits.
- R3: With prog_busy high and rd_addr equal to ld_addr, bits 7 and 15 of bus_q are the inverse of bits 7 and 15 of ld_data.
- R4: With prog_busy high and rd_addr different from ld_addr, bits 7 and 15 carry array_q.
- R5: With prog_busy high, bits 6 and 14 both read 0 in the first access after prog_busy rises, and each later access reads the inverse of the one before.
- R6: An access starts on the first sampled cycle of the read condition. Holding the condition keeps one toggle value, and strobing either chip_sel_n or out_en_n starts a new access.
- R7: With prog_busy high, every bit other than 6, 7, 14 and 15 carries array_q.
- R8: A rise of prog_busy clears the toggle state, even when the previous cycle ended with an odd number of accesses.
- R9: With prog_busy low, bits 6 and 14 carry array_q and the toggle state stays frozen.
- R10: A cycle with wr_en_n=0 neither drives the bus nor counts as an access for the toggle sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| chip_sel_n | input | 1 | chip select, active low |
| out_en_n | input | 1 | output enable, active low |
| wr_en_n | input | 1 | write enable, active low |
| rd_addr | input | 16 | read address |
| array_q | input | 16 | array contents at rd_addr |
| prog_busy | input | 1 | program timer running |
| ld_addr | input | 16 | address of the last loaded word |
| ld_data | input | 16 | data of the last loaded word |
| bus_q | output | 16 | read data, registered |
| bus_drive | output | 1 | 1 = bus driven, 0 = high impedance |

## Verification
The bench sweeps reads with the timer idle and busy, through every combination of the two polled bits in the loaded word, and alternates the address between the loaded word and other words. A design that inverted status on every address, or on no address, would fail the polled-bit comparisons. A design that advanced the toggle on each clock, or only on output-enable strobes, would show a wrong toggle value in long held accesses or in chip-select strobed reads. A design that missed the clear on busy rise, counted write-enabled cycles as reads, or kept toggling after completion would be caught by the reads that follow those events.

// File: rtl/status_readback_pkg.sv
package status_readback_pkg;
  localparam int LANE_W = 8;
  localparam int POLL_OFS = 7;
  localparam int TOG_OFS = 6;

  function automatic logic is_poll_bit(input int idx);
    return (idx % LANE_W) == POLL_OFS;
  endfunction

  function automatic logic is_tog_bit(input int idx);
    return (idx % LANE_W) == TOG_OFS;
  endfunction
endpackage

// File: rtl/srb_access_det.sv
module srb_access_det (
  input  logic clk,
  input  logic rst_n,
  input  logic chip_sel_n,
  input  logic out_en_n,
  input  logic wr_en_n,
  input  logic busy,
  output logic rd_cond,
  output logic acc_start,
  output logic busy_rise
);
  logic cond_prev_q;
  logic busy_prev_q;

  assign rd_cond   = !chip_sel_n && !out_en_n && wr_en_n;
  assign acc_start = rd_cond && !cond_prev_q;
  assign busy_rise = busy && !busy_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_prev_q <= 1'b0;
      busy_prev_q <= 1'b0;
    end else begin
      cond_prev_q <= rd_cond;
      busy_prev_q <= busy;
    end
  end

  // R6
  held_access_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cond |=> (rd_cond -> !acc_start));
endmodule

// File: rtl/srb_toggle_trk.sv
module srb_toggle_trk (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_start,
  input  logic busy,
  input  logic busy_rise,
  output logic tog_now
);
  logic tog_q;
  logic acc_tog_q;
  logic tog_eff;

  assign tog_eff = busy_rise ? 1'b0 : tog_q;
  assign tog_now = acc_start ? tog_eff : acc_tog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q     <= 1'b0;
      acc_tog_q <= 1'b0;
    end else begin
      if (busy_rise)
        tog_q <= acc_start;
      else if (acc_start && busy)
        tog_q <= ~tog_q;
      if (acc_start)
        acc_tog_q <= tog_eff;
      else if (busy_rise)
        acc_tog_q <= 1'b0;
    end
  end

  // R5
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_start && busy && !busy_rise) |=> (tog_q != $past(tog_q)));
  // R8
  toggle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_rise && !acc_start) |=> (tog_q == 1'b0));
  // R9
  toggle_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(tog_q));
endmodule

// File: rtl/srb_status_merge.sv
module srb_status_merge #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16
) (
  input  logic [DATA_W-1:0] array_q,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              busy,
  input  logic              tog_now,
  output logic [DATA_W-1:0] merged
);
  import status_readback_pkg::*;

  logic hit_last;
  assign hit_last = (rd_addr == ld_addr);

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (is_poll_bit(i)) begin : g_poll
      assign merged[i] = (busy && hit_last) ? ~ld_data[i] : array_q[i];
    end else if (is_tog_bit(i)) begin : g_tog
      assign merged[i] = busy ? tog_now : array_q[i];
    end else begin : g_pass
      assign merged[i] = array_q[i];
    end
  end
endmodule

// File: rtl/status_readback.sv
module status_readback #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_sel_n,
  input  logic              out_en_n,
  input  logic              wr_en_n,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] array_q,
  input  logic              prog_busy,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  output logic [DATA_W-1:0] bus_q,
  output logic              bus_drive
);
  logic rd_cond, acc_start, busy_rise, tog_now;
  logic [DATA_W-1:0] merged;

  srb_access_det u_det (
    .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .out_en_n(out_en_n),
    .wr_en_n(wr_en_n), .busy(prog_busy), .rd_cond(rd_cond),
    .acc_start(acc_start), .busy_rise(busy_rise)
  );

  srb_toggle_trk u_tog (
    .clk(clk), .rst_n(rst_n), .acc_start(acc_start), .busy(prog_busy),
    .busy_rise(busy_rise), .tog_now(tog_now)
  );

  srb_status_merge #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_merge (
    .array_q(array_q), .rd_addr(rd_addr), .ld_addr(ld_addr), .ld_data(ld_data),
    .busy(prog_busy), .tog_now(tog_now), .merged(merged)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_drive <= 1'b0;
      bus_q     <= '0;
    end else begin
      bus_drive <= rd_cond;
      bus_q     <= rd_cond ? merged : '0;
    end
  end

  // R1
  drive_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_sel_n && !out_en_n && wr_en_n) |=> bus_drive);
  // R1
  float_otherwise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!chip_sel_n && !out_en_n && wr_en_n) |=> (!bus_drive && bus_q == '0));
  // R2
  true_data_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_drive && !$past(prog_busy)) |-> (bus_q == $past(array_q)));
  // R3
  poll_invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_drive && $past(prog_busy) && $past(rd_addr == ld_addr))
      |-> (bus_q[7] == ~$past(ld_data[7])));
endmodule

// File: tb/sim_status_readback.sv
module sim_status_readback;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chip_sel_n = 1'b1, out_en_n = 1'b1, wr_en_n = 1'b1;
  logic [15:0] rd_addr = '0, ld_addr = '0, ld_data = '0;
  logic [15:0] array_q, bus_q;
  logic prog_busy = 1'b0, bus_drive;

  int n_cmp = 0, n_bad = 0, tcnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [15:0] arr(input logic [15:0] a);
    return (a * 16'h9E37) ^ 16'h5A5A;
  endfunction
  assign array_q = arr(rd_addr);

  status_readback u0 (
    .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .out_en_n(out_en_n),
    .wr_en_n(wr_en_n), .rd_addr(rd_addr), .array_q(array_q), .prog_busy(prog_busy),
    .ld_addr(ld_addr), .ld_data(ld_data), .bus_q(bus_q), .bus_drive(bus_drive)
  );

  task automatic chk(input string req, input logic [16:0] act, input logic [16:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expect_word(input logic [15:0] a, input bit t);
    logic [15:0] e = arr(a);
    if (prog_busy) begin
      if (a == ld_addr) begin e[7] = ~ld_data[7]; e[15] = ~ld_data[15]; end
      e[6] = t; e[14] = t;
    end
    return e;
  endfunction

  task automatic set_busy(input bit b);
    @(negedge clk);
    prog_busy = b;
    if (b) tcnt = 0;
  endtask

  // cs_strobe: access strobed by chip_sel_n while out_en_n stays low
  task automatic do_read(input logic [15:0] a, input bit cs_strobe, input int hold, input string req);
    bit t = tcnt[0];
    logic [15:0] e;
    @(negedge clk);
    rd_addr = a;
    if (cs_strobe) begin out_en_n = 1'b0; chip_sel_n = 1'b0; end
    else begin chip_sel_n = 1'b0; out_en_n = 1'b0; end
    e = expect_word(a, t);
    if (prog_busy) tcnt++;
    for (int k = 0; k <= hold; k++) begin
      @(posedge clk); #1;
      chk(req, {bus_drive, bus_q}, {1'b1, e});
    end
    @(negedge clk);
    if (cs_strobe) chip_sel_n = 1'b1; else out_en_n = 1'b1;
    @(posedge clk); #1;
    chk("R1", {bus_drive, bus_q}, 17'h0);
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 chk("R1", {bus_drive, bus_q}, 17'h0);
    @(negedge clk); rst_n = 1'b1;

    // R2: idle reads over many addresses, both strobe styles
    for (int a = 0; a < 40; a++)
      do_read(16'(a * 1237), a[0], a % 3, "R2");

    // R3/R4/R7/R5: busy episodes over all polled-bit patterns
    ld_addr = 16'h0123;
    for (int p = 0; p < 4; p++) begin
      ld_data = 16'h3C3C ^ {p[1], 7'h0, p[0], 7'h0};
      set_busy(1'b1);
      for (int r = 0; r < 8; r++) begin
        if (r[0]) do_read(ld_addr, r[1], 0, "R3");
        else      do_read(16'(r * 911 + p), r[1], 0, "R4");
      end
      // R8: end with odd count, next cycle must restart at 0
      do_read(16'h7777, 1'b0, 0, "R7");
      set_busy(1'b0);
      // R9: after completion, true data, toggle frozen
      do_read(ld_addr, 1'b0, 0, "R9");
      do_read(ld_addr, 1'b1, 0, "R9");
    end

    // R8: fresh cycle starts at toggle 0
    set_busy(1'b1);
    do_read(16'h0050, 1'b0, 0, "R8");
    // R6: a long held access keeps one value; chip-select strobes advance
    do_read(16'h0051, 1'b0, 5, "R6");
    do_read(16'h0052, 1'b1, 3, "R6");
    do_read(16'h0053, 1'b1, 0, "R6");

    // R10: write-enabled cycle neither drives nor counts
    @(negedge clk);
    chip_sel_n = 1'b0; out_en_n = 1'b0; wr_en_n = 1'b0;
    @(posedge clk); #1;
    chk("R10", {bus_drive, bus_q}, 17'h0);
    @(negedge clk);
    chip_sel_n = 1'b1; out_en_n = 1'b1;
    @(negedge clk);
    wr_en_n = 1'b1;
    do_read(16'h0054, 1'b0, 0, "R10");
    set_busy(1'b0);
    do_read(16'h0054, 1'b0, 0, "R9");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule